// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides whether an instruction runs. It takes the 4-bit condition field of an instruction word and the four status flags: negative, zero, carry and overflow. It returns a 2-bit result. Bit 0 means "execute". Bit 1 means the field holds the reserved code 15. That code belongs to a separate class of unconditional instructions, so the decoder must send it down its own path instead of treating it as a plain pass or a plain fail.

The parameter `REGISTERED` selects one of two builds:

- **Combinational build (default):** the result follows the inputs with no delay, and `out_valid` simply mirrors `in_valid`.
- **Registered build:** the evaluation is captured one clock after an input marked valid. The previous result is held while no valid input arrives.

Top module: `cond_gate`

## Requirements
- R1: Code 0 executes exactly when the zero flag is 1. Code 1 executes exactly when the zero flag is 0.
- R2: Codes 2 and 3 execute when carry is 1 and 0 respectively. Codes 4 and 5 do the same for negative. Codes 6 and 7 do the same for overflow.
- R3: Code 8 executes when carry is 1 and zero is 0. Code 9 executes when zero is 1 or carry is 0.
- R4: Code 10 executes when negative equals overflow. Code 11 executes when they differ.
- R5: Code 12 executes when zero is 0 and negative equals overflow. Code 13 executes when zero is 1 or negative differs from overflow.
- R6: Code 14 gives result 2'b01 for every flag value.
- R7: Code 15 gives result 2'b10 (bit 1 = special class, bit 0 = execute) for every flag value. Codes 0 to 14 always have bit 1 clear.
- R8: The result is never 2'b11, so execute is 0 whenever the special bit is 1.
- R9: In the combinational build, `result` reflects the current `cond` and flags in the same cycle, and `out_valid` equals `in_valid`.
- R10: In the registered build, a valid input's evaluation appears on `result` with `out_valid` high at the first rising edge after it is presented. A cycle without `in_valid` drives `out_valid` low at the next edge.
- R11: In the registered build, `result` keeps its value across edges where `in_valid` is low.
- R12: In the registered build, while `rst_n` is low, `out_valid` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the registered build and the checks) |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Marks `cond` and the flags as meaningful |
| cond | input | 4 | Condition field of the instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| out_valid | output | 1 | Result qualifier |
| result | output | 2 | Bit 0 execute, bit 1 special unconditional class |

## Verification
The embedded properties assume that the inputs settle before each rising edge and do not change at that edge. The bench meets this by changing the inputs only on falling edges.

For the registered build, the properties also assume that `in_valid` is a clean level, known from the first edge after reset. The bench holds `in_valid` low during reset and drives it from the random source only after reset is released.

Each of the 256 combinations of condition code and flags is applied once. Random inputs then mix valid and idle cycles so that the hold behaviour is exercised.

// File: rtl/cond_gate.sv
module cond_gate #(
  parameter bit REGISTERED = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [3:0] cond,
  input  logic       flag_n,
  input  logic       flag_z,
  input  logic       flag_c,
  input  logic       flag_v,
  output logic       out_valid,
  output logic [1:0] result
);

  localparam logic [3:0] CODE_ALWAYS  = 4'd14;
  localparam logic [3:0] CODE_SPECIAL = 4'd15;

  logic       base;
  logic       pass;
  logic [1:0] eval;
  logic       nv_eq;

  assign nv_eq = (flag_n == flag_v);

  always_comb begin
    case (cond[3:1])
      3'd0:    base = flag_z;
      3'd1:    base = flag_c;
      3'd2:    base = flag_n;
      3'd3:    base = flag_v;
      3'd4:    base = flag_c & ~flag_z;
      3'd5:    base = nv_eq;
      3'd6:    base = ~flag_z & nv_eq;
      default: base = 1'b1;
    endcase
  end

  assign pass = (cond == CODE_ALWAYS) ? 1'b1 : (base ^ cond[0]);
  assign eval = (cond == CODE_SPECIAL) ? 2'b10 : {1'b0, pass};

  // R8
  no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result != 2'b11);

  generate
    if (REGISTERED) begin : g_reg
      logic [1:0] res_q;
      logic       vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q <= 2'b00;
          vld_q <= 1'b0;
        end else begin
          vld_q <= in_valid;
          if (in_valid) res_q <= eval;
        end
      end

      assign result    = res_q;
      assign out_valid = vld_q;

      // R10
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R10
      idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      // R11
      hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
      // R7
      special_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond == CODE_SPECIAL) |=> result == 2'b10);
      // R6
      always_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond == CODE_ALWAYS) |=> result == 2'b01);
    end else begin : g_comb
      assign result    = eval;
      assign out_valid = in_valid;

      // R9
      valid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
      // R7
      special_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == CODE_SPECIAL) |-> result == 2'b10);
      // R6
      always_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == CODE_ALWAYS) |-> result == 2'b01);
      // R1
      zero_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'd0) |-> result[0] == flag_z);
    end
  endgenerate

endmodule

// File: tb/cond_gate_tb_top.sv
module cond_gate_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] cond = 4'd0;
  logic       fn = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;
  logic       ov_c, ov_r;
  logic [1:0] res_c, res_r;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] exp_r;
  logic       exp_vr;

  always #10 clk = ~clk;

  cond_gate #(.REGISTERED(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond),
    .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
    .out_valid(ov_c), .result(res_c));

  cond_gate #(.REGISTERED(1'b1)) dut_reg_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond),
    .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
    .out_valid(ov_r), .result(res_r));

  function automatic logic [1:0] ref_eval(input logic [3:0] c,
      input logic n, input logic z, input logic cy, input logic v);
    logic e;
    case (c)
      4'd0:  e = z;
      4'd1:  e = !z;
      4'd2:  e = cy;
      4'd3:  e = !cy;
      4'd4:  e = n;
      4'd5:  e = !n;
      4'd6:  e = v;
      4'd7:  e = !v;
      4'd8:  e = cy && !z;
      4'd9:  e = z || !cy;
      4'd10: e = (n == v);
      4'd11: e = (n != v);
      4'd12: e = !z && (n == v);
      4'd13: e = z || (n != v);
      4'd14: e = 1'b1;
      default: return 2'b10;
    endcase
    return {1'b0, e};
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    if (c <= 4'd1) return "R1";
    if (c <= 4'd7) return "R2";
    if (c <= 4'd9) return "R3";
    if (c <= 4'd11) return "R4";
    if (c <= 4'd13) return "R5";
    if (c == 4'd14) return "R6";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cond=%0d nzcv=%b%b%b%b actual=%b expected=%b",
               tag, cond, fn, fz, fc, fv, act, exp);
    end
  endtask

  // drive on falling edge, check comb half a phase later, check reg after next rising edge
  task automatic apply(input logic vld, input logic [3:0] c,
                       input logic n, input logic z, input logic cy, input logic v);
    logic [1:0] e;
    @(negedge clk);
    in_valid = vld; cond = c; fn = n; fz = z; fc = cy; fv = v;
    e = ref_eval(c, n, z, cy, v);
    #5;
    check(tag_of(c), res_c, e);
    check("R8", {1'b0, res_c == 2'b11}, 2'b00);
    check("R9", {1'b0, ov_c}, {1'b0, vld});
    if (vld) exp_r = e;
    exp_vr = vld;
    @(posedge clk);
    #5;
    check(vld ? "R10" : "R11", res_r, exp_r);
    check("R10", {1'b0, ov_r}, {1'b0, exp_vr});
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd7);
    exp_r = 2'b00;
    exp_vr = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    // R12: reset state of the registered build
    check("R12", res_r, 2'b00);
    check("R12", {1'b0, ov_r}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < 256; k++) begin
      logic [7:0] kk;
      kk = k[7:0];
      apply(1'b1, kk[7:4], kk[3], kk[2], kk[1], kk[0]);
    end

    // R7 corners: code 15 with all flags set, then all clear
    apply(1'b1, 4'd15, 1'b1, 1'b1, 1'b1, 1'b1);
    apply(1'b1, 4'd15, 1'b0, 1'b0, 1'b0, 1'b0);
    // R11: idle cycles hold the special result
    apply(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    apply(1'b0, 4'd14, 1'b1, 1'b0, 1'b1, 1'b0);

    for (int k = 0; k < 400; k++) begin
      logic [7:0] r;
      logic vld;
      r = 8'($urandom);
      vld = ($urandom % 3) != 0;
      apply(vld, r[7:4], r[3], r[2], r[1], r[0]);
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule